// File: doc/BRIEF.md
# Factor-to-Variable Gaussian Message Engine

This block produces one outgoing Gaussian message from an equation node to a single unknown of a sparse linear system solved by iterative message passing. Each input packet is one 64-bit stream. The first beat gives the coefficient that the target unknown has in this equation. After it come (message, coefficient) beat pairs, one pair for each other unknown in the equation and one for the right-hand-side node. The engine reduces the packet to a mean and a precision and emits both in a single 64-bit beat.

All fields are signed fixed point with 16 fractional bits (Q16.16). The mean path accumulates each incoming mean weighted by its coefficient and divides the total by the negated target coefficient. The precision path accumulates squared coefficients divided by the incoming precisions. It then takes the reciprocal of that sum and scales it by the squared target coefficient. All divisions run on one shared sequential divider. The engine holds only one packet at a time: while a divide is running, input is stalled.

Top module: `fvm_engine`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid`, `pkt_malformed` and `arith_err` are 0.
- R2: Beat position decides how a beat is used. Beat 1 holds the target coefficient. Every even beat is a message, with the mean in bits 63:32 and the precision in bits 31:0. Every odd beat from beat 3 on is the coefficient paired with the message just before it. For coefficient beats only bits 63:32 are read; bits 31:0 have no effect.
- R3: Each pair adds floor(mean·coef / 2^16), saturated to 48 bits, to a 48-bit saturating mean sum S. The output mean is trunc(S·2^16 / −A), saturated to 32 bits, where A is the target coefficient. Division truncates toward zero.
- R4: Each pair with a nonzero precision adds trunc(coef² / prec) to a 48-bit saturating sum P; coef² is the raw 64-bit product of the two fields. R = trunc(2^32 / P), saturated to 32 bits. The output precision is floor(floor(A²/2^16)·R / 2^16), saturated to 32 bits.
- R5: The output beat carries the mean in bits 63:32 and the precision in bits 31:0. While `out_ready` is 0 the beat is held: `out_valid` stays 1 and `out_data` does not change.
- R6: `in_ready` is 0 from the edge that accepts a coefficient beat until that pair's divide is done. From the final beat of a good packet until its result is accepted, `in_ready` is also 0.
- R7: A packet whose last beat is a message beat, or that has a single beat, is malformed. It produces no output beat, and `pkt_malformed` pulses for exactly one cycle right after that last beat is accepted.
- R8: A zero message precision skips that pair's precision term, forces the output precision to 0 and sets `arith_err`; the mean is unaffected.
- R9: A zero target coefficient forces both output fields to 0 and sets `arith_err`.
- R10: A zero precision sum P forces the output precision to 0 and sets `arith_err`.
- R11: `arith_err` is sticky: once set, it stays 1 until reset.
- R12: Results outside the 32-bit range saturate to 0x7FFFFFFF or 0x80000000.
- R13: Both sums start from zero for every packet, including the packet after a malformed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Engine accepts a beat |
| in_data | input | 64 | Input beat |
| in_last | input | 1 | Final beat of the packet |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | 64 | Mean (63:32) and precision (31:0) |
| pkt_malformed | output | 1 | One-cycle pulse for a dropped malformed packet |
| arith_err | output | 1 | Sticky arithmetic error flag |

## Verification
The assertions assume that the source follows the valid/ready rule and never raises `in_last` on a beat that is not valid. They also assume that the divider is started only while idle, which holds because input is refused while a divide runs. The bench drives inputs only at the falling edge and waits on `in_ready` before moving to the next beat. Random packets use nonzero coefficients and positive precisions of moderate size, so every error flag and saturation case comes from a directed packet built for that purpose.

// File: rtl/fvm_pkg.sv
// Package: fvm_pkg
// Shared defaults and types for the factor-to-variable message engine.
// Assumes Q16.16 fields packed two to a 64-bit beat.
package fvm_pkg;
    localparam int unsigned FIELD_W_DEF = 32;
    localparam int unsigned FRAC_W_DEF  = 16;
    localparam int unsigned ACC_W_DEF   = 48;

    typedef enum logic [2:0] {
        ST_COLLECT,
        ST_TERM,
        ST_MEAN,
        ST_RECIP,
        ST_EMIT
    } eng_state_e;
endpackage

// File: rtl/fvm_sat.sv
// Module: fvm_sat
// Narrows a signed value to OUT_W bits and clamps to the signed limits.
// Assumes IN_W > OUT_W.
module fvm_sat #(
    parameter int unsigned IN_W  = 64,
    parameter int unsigned OUT_W = 32
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    localparam logic [OUT_W-1:0] MAXV = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MINV = {1'b1, {(OUT_W-1){1'b0}}};

    logic [IN_W-OUT_W:0] top_bits;

    // Pass through when all dropped bits match the sign, else clamp.
    always_comb begin
        top_bits = din[IN_W-1:OUT_W-1];
        if ((&top_bits) || !(|top_bits)) begin
            dout = din[OUT_W-1:0];
        end else begin
            dout = din[IN_W-1] ? MINV : MAXV;
        end
    end
endmodule

// File: rtl/fvm_seq_div.sv
// Module: fvm_seq_div
// Signed restoring divider, one quotient bit per cycle, result truncated
// toward zero. Assumes start is raised only while idle. A zero divisor
// gives an undefined quotient that the caller must discard.
module fvm_seq_div #(
    parameter int unsigned NUM_W = 64,
    parameter int unsigned DEN_W = 48
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic signed [NUM_W-1:0] num,
    input  logic signed [DEN_W-1:0] den,
    output logic                    busy,
    output logic                    done,
    output logic signed [NUM_W-1:0] quo
);
    localparam int unsigned CW = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] q_r, q_nx;
    logic [DEN_W:0]   rem_r, rem_sh, rem_nx;
    logic [DEN_W-1:0] dmag_r;
    logic             neg_r, busy_r, done_r, ge;
    logic [CW-1:0]    cnt_r;

    // One restoring step: shift in the next dividend bit, subtract if it fits.
    always_comb begin
        rem_sh = {rem_r[DEN_W-1:0], q_r[NUM_W-1]};
        ge     = (rem_sh >= {1'b0, dmag_r});
        rem_nx = ge ? (rem_sh - {1'b0, dmag_r}) : rem_sh;
        q_nx   = {q_r[NUM_W-2:0], ge};
    end

    // Load magnitudes on start, then iterate NUM_W times.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r    <= '0;
            rem_r  <= '0;
            dmag_r <= '0;
            neg_r  <= 1'b0;
            busy_r <= 1'b0;
            done_r <= 1'b0;
            cnt_r  <= '0;
        end else if (start) begin
            q_r    <= num[NUM_W-1] ? -num : num;
            dmag_r <= den[DEN_W-1] ? -den : den;
            neg_r  <= num[NUM_W-1] ^ den[DEN_W-1];
            rem_r  <= '0;
            cnt_r  <= CW'(NUM_W);
            busy_r <= 1'b1;
            done_r <= 1'b0;
        end else if (busy_r) begin
            q_r   <= q_nx;
            rem_r <= rem_nx;
            cnt_r <= cnt_r - 1'b1;
            if (cnt_r == CW'(1)) begin
                busy_r <= 1'b0;
                done_r <= 1'b1;
            end
        end else begin
            done_r <= 1'b0;
        end
    end

    assign busy = busy_r;
    assign done = done_r;
    assign quo  = neg_r ? -$signed(q_r) : $signed(q_r);

    // R6
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy_r);
endmodule

// File: rtl/fvm_beat_router.sv
// Module: fvm_beat_router
// Tracks beat position in a packet and splits beats into the target
// coefficient, held messages and coefficient pairs. Assumes beat_last
// is only meaningful together with beat_fire.
module fvm_beat_router #(
    parameter int unsigned FIELD_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      beat_fire,
    input  logic [2*FIELD_W-1:0]      beat_data,
    input  logic                      beat_last,
    output logic signed [FIELD_W-1:0] tgt_coef,
    output logic                      pair_fire,
    output logic signed [FIELD_W-1:0] pair_mean,
    output logic signed [FIELD_W-1:0] pair_prec,
    output logic signed [FIELD_W-1:0] pair_coef,
    output logic                      end_good,
    output logic                      end_bad
);
    logic                      past_first, want_coef;
    logic                      is_tgt, is_msg, is_coef;
    logic signed [FIELD_W-1:0] tgt_r, held_mean, held_prec;
    logic        [FIELD_W-1:0] hi_half, lo_half;

    // Classify the current beat from the position state.
    always_comb begin
        hi_half = beat_data[2*FIELD_W-1:FIELD_W];
        lo_half = beat_data[FIELD_W-1:0];
        is_tgt  = !past_first;
        is_msg  = past_first && !want_coef;
        is_coef = past_first && want_coef;
    end

    // Advance the position state; a last beat returns it to the start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_first <= 1'b0;
            want_coef  <= 1'b0;
        end else if (beat_fire) begin
            if (beat_last) begin
                past_first <= 1'b0;
                want_coef  <= 1'b0;
            end else if (is_tgt) begin
                past_first <= 1'b1;
                want_coef  <= 1'b0;
            end else begin
                want_coef <= !want_coef;
            end
        end
    end

    // Capture the target coefficient and the pending message.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_r     <= '0;
            held_mean <= '0;
            held_prec <= '0;
        end else if (beat_fire) begin
            if (is_tgt) begin
                tgt_r <= hi_half;
            end
            if (is_msg) begin
                held_mean <= hi_half;
                held_prec <= lo_half;
            end
        end
    end

    assign tgt_coef  = tgt_r;
    assign pair_fire = beat_fire && is_coef;
    assign pair_mean = held_mean;
    assign pair_prec = held_prec;
    assign pair_coef = hi_half;
    assign end_good  = beat_fire && beat_last && is_coef;
    assign end_bad   = beat_fire && beat_last && !is_coef;
endmodule

// File: rtl/fvm_engine.sv
// Module: fvm_engine
// Computes one factor-to-variable Gaussian message (mean, precision) from
// a positional packet. Q16.16 fields, 48-bit saturating sums, one shared
// sequential divider. Assumes the upstream source obeys valid/ready.
module fvm_engine
    import fvm_pkg::*;
#(
    parameter int unsigned FIELD_W = FIELD_W_DEF,
    parameter int unsigned FRAC_W  = FRAC_W_DEF,
    parameter int unsigned ACC_W   = ACC_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [2*FIELD_W-1:0] in_data,
    input  logic                 in_last,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [2*FIELD_W-1:0] out_data,
    output logic                 pkt_malformed,
    output logic                 arith_err
);
    localparam int unsigned NUM_W  = 2 * FIELD_W;
    localparam int unsigned PROD_W = ACC_W + FIELD_W;

    typedef logic signed [NUM_W-1:0]  wide_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic signed [ACC_W:0]    acc1_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    eng_state_e st;
    logic signed [FIELD_W-1:0] aki, pair_mean, pair_prec, pair_coef;
    logic signed [FIELD_W-1:0] mean_r, prec_r, q32, prec_calc;
    logic                      pair_fire, end_good, end_bad, beat_fire;
    acc_t                      msum_r, psum_r, mterm, pterm, msum_nx, psum_nx, aki2q;
    acc1_t                     msum_add, psum_add;
    wide_t                     mprod, mterm_sh, sq_coef, aki2, div_num, div_q;
    acc_t                      div_den;
    prod_t                     pprod;
    logic                      div_start, div_busy, div_done;
    logic                      skip_term_r, fin_pend_r, prec_bad_r, launch_r, bad_r, err_r;

    assign beat_fire = in_valid && in_ready;

    fvm_beat_router #(.FIELD_W(FIELD_W)) u_router (
        .clk(clk), .rst_n(rst_n),
        .beat_fire(beat_fire), .beat_data(in_data), .beat_last(in_last),
        .tgt_coef(aki), .pair_fire(pair_fire),
        .pair_mean(pair_mean), .pair_prec(pair_prec), .pair_coef(pair_coef),
        .end_good(end_good), .end_bad(end_bad)
    );

    // Weighted-mean term and squared coefficients.
    always_comb begin
        mprod    = wide_t'(pair_mean) * wide_t'(pair_coef);
        mterm_sh = mprod >>> FRAC_W;
        sq_coef  = wide_t'(pair_coef) * wide_t'(pair_coef);
        aki2     = wide_t'(aki) * wide_t'(aki);
        aki2q    = acc_t'(aki2 >>> FRAC_W);
        msum_add = acc1_t'(msum_r) + acc1_t'(mterm);
        psum_add = acc1_t'(psum_r) + acc1_t'(pterm);
        pprod    = (prod_t'(aki2q) * prod_t'(q32)) >>> FRAC_W;
    end

    fvm_sat #(.IN_W(NUM_W),   .OUT_W(ACC_W))   u_sat_mterm (.din(mterm_sh), .dout(mterm));
    fvm_sat #(.IN_W(ACC_W+1), .OUT_W(ACC_W))   u_sat_msum  (.din(msum_add), .dout(msum_nx));
    fvm_sat #(.IN_W(NUM_W),   .OUT_W(ACC_W))   u_sat_pterm (.din(div_q),    .dout(pterm));
    fvm_sat #(.IN_W(ACC_W+1), .OUT_W(ACC_W))   u_sat_psum  (.din(psum_add), .dout(psum_nx));
    fvm_sat #(.IN_W(NUM_W),   .OUT_W(FIELD_W)) u_sat_q32   (.din(div_q),    .dout(q32));
    fvm_sat #(.IN_W(PROD_W),  .OUT_W(FIELD_W)) u_sat_prec  (.din(pprod),    .dout(prec_calc));

    // Select divider operands for the pair term, final mean or reciprocal.
    always_comb begin
        unique case (st)
            ST_MEAN: begin
                div_num = wide_t'(msum_r) <<< FRAC_W;
                div_den = -acc_t'(aki);
            end
            ST_RECIP: begin
                div_num = wide_t'(1) <<< (2 * FRAC_W);
                div_den = psum_r;
            end
            default: begin
                div_num = sq_coef;
                div_den = acc_t'(pair_prec);
            end
        endcase
        div_start = ((st == ST_COLLECT) && pair_fire) || launch_r;
    end

    fvm_seq_div #(.NUM_W(NUM_W), .DEN_W(ACC_W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .num(div_num), .den(div_den),
        .busy(div_busy), .done(div_done), .quo(div_q)
    );

    // Packet sequencing, accumulation, finalisation and output hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_COLLECT;
            msum_r      <= '0;
            psum_r      <= '0;
            mean_r      <= '0;
            prec_r      <= '0;
            skip_term_r <= 1'b0;
            fin_pend_r  <= 1'b0;
            prec_bad_r  <= 1'b0;
            launch_r    <= 1'b0;
            bad_r       <= 1'b0;
            err_r       <= 1'b0;
        end else begin
            bad_r    <= 1'b0;
            launch_r <= 1'b0;
            unique case (st)
                ST_COLLECT: begin
                    if (pair_fire) begin
                        msum_r      <= msum_nx;
                        skip_term_r <= (pair_prec == '0);
                        fin_pend_r  <= end_good;
                        if (pair_prec == '0) begin
                            prec_bad_r <= 1'b1;
                            err_r      <= 1'b1;
                        end
                        st <= ST_TERM;
                    end else if (end_bad) begin
                        bad_r      <= 1'b1;
                        msum_r     <= '0;
                        psum_r     <= '0;
                        prec_bad_r <= 1'b0;
                    end
                end
                ST_TERM: begin
                    if (div_done) begin
                        if (!skip_term_r) begin
                            psum_r <= psum_nx;
                        end
                        if (fin_pend_r) begin
                            st       <= ST_MEAN;
                            launch_r <= 1'b1;
                        end else begin
                            st <= ST_COLLECT;
                        end
                    end
                end
                ST_MEAN: begin
                    if (div_done) begin
                        mean_r   <= (aki == '0) ? '0 : q32;
                        if (aki == '0) begin
                            err_r <= 1'b1;
                        end
                        st       <= ST_RECIP;
                        launch_r <= 1'b1;
                    end
                end
                ST_RECIP: begin
                    if (div_done) begin
                        prec_r <= ((aki == '0) || (psum_r == '0) || prec_bad_r) ? '0 : prec_calc;
                        if (psum_r == '0) begin
                            err_r <= 1'b1;
                        end
                        st <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (out_ready) begin
                        st         <= ST_COLLECT;
                        msum_r     <= '0;
                        psum_r     <= '0;
                        prec_bad_r <= 1'b0;
                    end
                end
                default: st <= ST_COLLECT;
            endcase
        end
    end

    assign in_ready      = (st == ST_COLLECT);
    assign out_valid     = (st == ST_EMIT);
    assign out_data      = {mean_r, prec_r};
    assign pkt_malformed = bad_r;
    assign arith_err     = err_r;

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R6
    pair_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pair_fire |=> !in_ready);

    // R7
    bad_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_malformed |-> !out_valid);

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arith_err |=> arith_err);
endmodule

// File: tb/fvm_engine_test.sv
module fvm_engine_test;
    timeunit 1ns;
    timeprecision 100ps;

    typedef logic signed [127:0] big_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_data = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_data;
    logic        pkt_malformed;
    logic        arith_err;

    int n_chk = 0;
    int n_bad = 0;

    logic signed [31:0] aki_v;
    logic signed [31:0] pm [8];
    logic signed [31:0] pt [8];
    logic signed [31:0] pc [8];
    int np;

    always #2.5 clk = ~clk;

    fvm_engine uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .pkt_malformed(pkt_malformed), .arith_err(arith_err)
    );

    function automatic logic signed [31:0] qv(input real r);
        return 32'($rtoi(r * 65536.0));
    endfunction

    function automatic big_t clampw(input big_t v, input int w);
        big_t hi, lo;
        hi = (big_t'(1) <<< (w - 1)) - 1;
        lo = -(big_t'(1) <<< (w - 1));
        return (v > hi) ? hi : ((v < lo) ? lo : v);
    endfunction

    // Expected output beat and error condition from the requirement formulas.
    function automatic logic [63:0] ref_out(output logic e);
        big_t ms, ps, t, a, mo, rc, po;
        logic zb;
        ms = 0; ps = 0; zb = 1'b0;
        a = big_t'(aki_v);
        for (int j = 0; j < np; j++) begin
            t  = clampw((big_t'(pm[j]) * big_t'(pc[j])) >>> 16, 48);
            ms = clampw(ms + t, 48);
            if (pt[j] == 0) begin
                zb = 1'b1;
            end else begin
                t  = clampw((big_t'(pc[j]) * big_t'(pc[j])) / big_t'(pt[j]), 48);
                ps = clampw(ps + t, 48);
            end
        end
        mo = (a == 0) ? big_t'(0) : clampw((ms <<< 16) / (-a), 32);
        if (a == 0 || ps == 0 || zb) begin
            po = 0;
        end else begin
            rc = clampw((big_t'(1) <<< 32) / ps, 32);
            po = clampw((((a * a) >>> 16) * rc) >>> 16, 32);
        end
        e = (a == 0) || (ps == 0) || zb;
        return {mo[31:0], po[31:0]};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Present one beat at a falling edge and hold it until accepted.
    task automatic send_beat(input logic [63:0] d, input logic l);
        in_data  = d;
        in_last  = l;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic send_pkt(input bit junk);
        send_beat({aki_v, junk ? $urandom : aki_v}, 1'b0);
        for (int j = 0; j < np; j++) begin
            send_beat({pm[j], pt[j]}, 1'b0);
            send_beat({pc[j], junk ? $urandom : pc[j]}, j == np - 1);
        end
    endtask

    task automatic get_out(output logic [63:0] d);
        d = 'x;
        for (int k = 0; k < 5000; k++) begin
            if (out_valid) begin
                d = out_data;
                @(negedge clk);
                return;
            end
            @(negedge clk);
        end
    endtask

    task automatic run_pkt(input string tag, input bit junk);
        logic [63:0] exp, got;
        logic e;
        exp = ref_out(e);
        send_pkt(junk);
        get_out(got);
        chk(tag, got, exp);
    endtask

    task automatic rand_pkt();
        np = 1 + int'($urandom % 4);
        aki_v = qv(0.25) + 32'($urandom % 245760);
        if ($urandom % 2) aki_v = -aki_v;
        for (int j = 0; j < np; j++) begin
            pm[j] = 32'($urandom % 1048576) - 32'sd524288;
            pt[j] = qv(0.5) + 32'($urandom % 1015808);
            pc[j] = qv(0.25) + 32'($urandom % 245760);
            if ($urandom % 2) pc[j] = -pc[j];
        end
        pc[np-1] = qv(-1.0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] got, exp;
        logic e;
        bit seen;
        void'($urandom(32'd52731));
        do_reset();

        // R1: idle outputs after reset
        chk("R1 reset state", {60'd0, in_ready, out_valid, pkt_malformed, arith_err}, 64'h8);

        // R3 R4 R6: two-pair packet; stall after a coefficient beat
        aki_v = qv(2.0); np = 2;
        pm[0] = qv(1.0); pt[0] = qv(1.0); pc[0] = qv(3.0);
        pm[1] = qv(6.0); pt[1] = qv(4.0); pc[1] = qv(-1.0);
        exp = ref_out(e);
        send_beat({aki_v, aki_v}, 1'b0);
        send_beat({pm[0], pt[0]}, 1'b0);
        send_beat({pc[0], pc[0]}, 1'b0);
        chk("R6 stall during pair divide", {63'd0, in_ready}, 64'd0);
        send_beat({pm[1], pt[1]}, 1'b0);
        send_beat({pc[1], pc[1]}, 1'b1);
        chk("R6 stall after final beat", {63'd0, in_ready}, 64'd0);
        get_out(got);
        chk("R3 R4 directed example", got, exp);

        // R2: lower halves of coefficient beats are ignored
        rand_pkt();
        run_pkt("R2 junk lower halves", 1'b1);

        // R5: held under back-pressure
        rand_pkt();
        exp = ref_out(e);
        out_ready = 1'b0;
        send_pkt(1'b0);
        get_out(got);
        for (int k = 0; k < 8; k++) begin
            chk("R5 held data", out_data, exp);
            chk("R6 input closed while holding", {62'd0, out_valid, in_ready}, 64'd2);
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        chk("R5 released", {63'd0, out_valid}, 64'd0);

        // R7: packet ending on a message beat
        aki_v = qv(1.0);
        send_beat({aki_v, aki_v}, 1'b0);
        send_beat({qv(5.0), qv(1.0)}, 1'b1);
        chk("R7 pulse on message-ended packet", {63'd0, pkt_malformed}, 64'd1);
        @(negedge clk);
        chk("R7 pulse lasts one cycle", {63'd0, pkt_malformed}, 64'd0);
        seen = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (out_valid) seen = 1'b1;
            @(negedge clk);
        end
        chk("R7 no output for malformed", {63'd0, seen}, 64'd0);
        // R7: single-beat packet
        send_beat({aki_v, aki_v}, 1'b1);
        chk("R7 pulse on single-beat packet", {63'd0, pkt_malformed}, 64'd1);
        // R13: next packet starts from clean sums
        rand_pkt();
        run_pkt("R13 after malformed", 1'b0);

        // R12: saturation of the mean field, both directions
        aki_v = qv(0.5); np = 2;
        pm[0] = qv(30000.0); pt[0] = qv(1.0); pc[0] = qv(1.0);
        pm[1] = 0;           pt[1] = qv(1.0); pc[1] = qv(-1.0);
        exp = ref_out(e);
        chk("R12 reference clamps low", {32'd0, exp[63:32]}, 64'h8000_0000);
        run_pkt("R12 negative saturation", 1'b0);
        pm[0] = qv(-30000.0);
        run_pkt("R12 positive saturation", 1'b0);

        // R3 R4 R13: random packets with random output stalls
        for (int i = 0; i < 20; i++) begin
            rand_pkt();
            exp = ref_out(e);
            out_ready = 1'b0;
            send_pkt(1'b0);
            repeat (int'($urandom % 4)) @(negedge clk);
            out_ready = 1'b1;
            get_out(got);
            chk("R3 R4 random packet", got, exp);
        end
        chk("R11 no error on clean traffic", {63'd0, arith_err}, 64'd0);

        // R8: zero message precision
        aki_v = qv(1.5); np = 2;
        pm[0] = qv(2.0); pt[0] = 0;        pc[0] = qv(1.0);
        pm[1] = qv(3.0); pt[1] = qv(2.0);  pc[1] = qv(-1.0);
        run_pkt("R8 zero precision", 1'b0);
        chk("R8 error flag", {63'd0, arith_err}, 64'd1);
        // R11: flag stays set through a clean packet
        rand_pkt();
        run_pkt("R11 clean packet after error", 1'b0);
        chk("R11 sticky flag", {63'd0, arith_err}, 64'd1);
        do_reset();
        chk("R1 flag cleared by reset", {63'd0, arith_err}, 64'd0);

        // R9: zero target coefficient
        aki_v = 0; np = 1;
        pm[0] = qv(4.0); pt[0] = qv(1.0); pc[0] = qv(-1.0);
        run_pkt("R9 zero target coefficient", 1'b0);
        chk("R9 error flag", {63'd0, arith_err}, 64'd1);
        do_reset();

        // R10: zero precision sum
        aki_v = qv(1.0); np = 1;
        pm[0] = qv(2.0); pt[0] = qv(1.0); pc[0] = 0;
        run_pkt("R10 zero precision sum", 1'b0);
        chk("R10 error flag", {63'd0, arith_err}, 64'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule